// File: doc/BRIEF.md
# Weighted Receive/Transmit DMA Arbiter

Two DMA engines, one moving received data and one moving data to transmit, share a single bus master. Each engine raises its own request line. The arbiter gives the bus to exactly one of them and keeps that grant until the owning engine pulses its burst-end line. After the burst ends, the bus stays idle for one cycle, and the next owner is chosen in that cycle.

The receive engine is favoured when both engines compete. In weighted mode, a 2-bit ratio code sets how many contended receive bursts are allowed before one transmit burst. The codes 00, 01, 10 and 11 give ratios of 1:1, 2:1, 3:1 and 4:1 (receive:transmit). A mode input switches to strict priority, where receive always wins a contended arbitration. When only one engine asks, it gets the bus at once.

Top module: `dma_pair_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both grants are low.
- R2: At most one grant is high at any time. A grant is issued only from a cycle in which neither grant is high, and it becomes visible on the clock edge that ends that idle cycle.
- R3: A grant stays high until the granted engine pulses its own burst-end input, and drops on the next edge. A burst-end pulse from the engine that does not hold the grant has no effect.
- R4: When the bus is idle and exactly one engine requests, that engine is granted on the next edge, whatever the weight count is.
- R5: With `strict_mode` high, a contended arbitration always grants receive.
- R6: With `strict_mode` low and both engines requesting continuously, grants repeat as (code+1) receive bursts followed by one transmit burst. Code 00 gives 1:1, 01 gives 2:1, 10 gives 3:1 and 11 gives 4:1.
- R7: The weight count rises only on contended receive grants in weighted mode, and clears on a contended transmit grant. Uncontended grants and strict-mode grants leave it unchanged.
- R8: A change of `ratio_code` clears the weight count. The new code is in force from the next arbitration.
- R9: With no request pending on an idle bus, the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_req | input | 1 | Receive engine requests the bus |
| tx_req | input | 1 | Transmit engine requests the bus |
| rx_done | input | 1 | Receive engine burst-end pulse |
| tx_done | input | 1 | Transmit engine burst-end pulse |
| ratio_code | input | RATIO_W (2) | Weight code: receive bursts per transmit burst, minus one |
| strict_mode | input | 1 | High: strict receive priority; low: weighted sharing |
| rx_gnt | output | 1 | Bus granted to receive engine |
| tx_gnt | output | 1 | Bus granted to transmit engine |

## Verification
The bench builds the block with the default `RATIO_W` of 2. With that width, all four ratio codes can be swept, and the 4:1 case, where the count reaches its ceiling of four, is exercised in full. A burst length of three cycles leaves room to change the ratio code, or a request line, while a grant is held. This makes it possible to test that the count is cleared by a code change and kept by an uncontended grant. A cycle-accurate behavioural model, fed with the same inputs, predicts both grants on every clock.

// File: rtl/arb_pair_pkg.sv
package arb_pair_pkg;

   // Bus owner; bit 0 is the receive grant, bit 1 the transmit grant
   typedef enum logic [1:0] {
      OWN_NONE = 2'b00,
      OWN_RX   = 2'b01,
      OWN_TX   = 2'b10
   } owner_e;

   // Outcome of one arbitration for the weight counter
   typedef struct packed {
      owner_e winner;
      logic   cnt_inc;
      logic   cnt_clr;
   } pick_t;

endpackage

// File: rtl/arb_weight_ctr.sv
module arb_weight_ctr #(
   parameter int RATIO_W = 2,
   parameter int CNT_W   = RATIO_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio_code,
   input  logic               fire,
   input  logic               inc,
   input  logic               clr,
   output logic [CNT_W-1:0]   cnt_eff,
   output logic [CNT_W-1:0]   cnt_lim
);

   logic [RATIO_W-1:0] code_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               code_chg;

   assign code_chg = (ratio_code != code_q);
   // a fresh code sees an empty count in the very cycle it appears
   assign cnt_eff  = code_chg ? '0 : cnt_q;
   assign cnt_lim  = CNT_W'(ratio_code) + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         cnt_q  <= '0;
      end else begin
         code_q <= ratio_code;
         if (fire && clr)
            cnt_q <= '0;
         else if (fire && inc)
            cnt_q <= cnt_eff + CNT_W'(1);
         else
            cnt_q <= cnt_eff;
      end
   end

endmodule

// File: rtl/arb_pick.sv
module arb_pick
   import arb_pair_pkg::*;
#(
   parameter int CNT_W = 3
) (
   input  logic             rx_req,
   input  logic             tx_req,
   input  logic             strict_mode,
   input  logic [CNT_W-1:0] cnt_eff,
   input  logic [CNT_W-1:0] cnt_lim,
   output pick_t            pick
);

   always_comb begin
      pick = '{winner: OWN_NONE, cnt_inc: 1'b0, cnt_clr: 1'b0};
      unique case ({rx_req, tx_req})
         2'b10: pick.winner = OWN_RX;
         2'b01: pick.winner = OWN_TX;
         2'b11: begin
            if (strict_mode) begin
               pick.winner = OWN_RX;
            end else if (cnt_eff >= cnt_lim) begin
               pick.winner  = OWN_TX;
               pick.cnt_clr = 1'b1;
            end else begin
               pick.winner  = OWN_RX;
               pick.cnt_inc = 1'b1;
            end
         end
         default: pick.winner = OWN_NONE;
      endcase
   end

endmodule

// File: rtl/arb_grant_hold.sv
module arb_grant_hold
   import arb_pair_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  owner_e winner,
   input  logic   rx_done,
   input  logic   tx_done,
   output logic   idle,
   output owner_e owner
);

   logic release_now;

   assign idle        = (owner == OWN_NONE);
   assign release_now = ((owner == OWN_RX) && rx_done) ||
                        ((owner == OWN_TX) && tx_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         owner <= OWN_NONE;
      else if (idle)
         owner <= winner;
      else if (release_now)
         owner <= OWN_NONE;
   end

endmodule

// File: rtl/dma_pair_arbiter.sv
module dma_pair_arbiter
   import arb_pair_pkg::*;
#(
   parameter int RATIO_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_req,
   input  logic               tx_req,
   input  logic               rx_done,
   input  logic               tx_done,
   input  logic [RATIO_W-1:0] ratio_code,
   input  logic               strict_mode,
   output logic               rx_gnt,
   output logic               tx_gnt
);

   localparam int CNT_W = RATIO_W + 1;

   generate
      if (RATIO_W < 1 || RATIO_W > 6) begin : g_bad_width
         $error("dma_pair_arbiter: RATIO_W must lie in 1..6");
      end
   endgenerate

   pick_t            pick;
   owner_e           owner;
   logic             idle;
   logic             fire;
   logic [CNT_W-1:0] cnt_eff;
   logic [CNT_W-1:0] cnt_lim;

   assign fire = idle && (pick.winner != OWN_NONE);

   arb_weight_ctr #(
      .RATIO_W (RATIO_W),
      .CNT_W   (CNT_W)
   ) u_weight (
      .clk        (clk),
      .rst_n      (rst_n),
      .ratio_code (ratio_code),
      .fire       (fire),
      .inc        (pick.cnt_inc),
      .clr        (pick.cnt_clr),
      .cnt_eff    (cnt_eff),
      .cnt_lim    (cnt_lim)
   );

   arb_pick #(
      .CNT_W (CNT_W)
   ) u_pick (
      .rx_req      (rx_req),
      .tx_req      (tx_req),
      .strict_mode (strict_mode),
      .cnt_eff     (cnt_eff),
      .cnt_lim     (cnt_lim),
      .pick        (pick)
   );

   arb_grant_hold u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .winner  (pick.winner),
      .rx_done (rx_done),
      .tx_done (tx_done),
      .idle    (idle),
      .owner   (owner)
   );

   assign rx_gnt = owner[0];
   assign tx_gnt = owner[1];

endmodule

// File: rtl/dma_pair_arbiter_chk.sv
module dma_pair_arbiter_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_req,
   input logic tx_req,
   input logic rx_done,
   input logic tx_done,
   input logic strict_mode,
   input logic rx_gnt,
   input logic tx_gnt
);

   logic bus_idle;
   assign bus_idle = !rx_gnt && !tx_gnt;

   // R2
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_gnt && tx_gnt));

   // R2
   rx_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_gnt) |-> ($past(bus_idle) && $past(rx_req)));

   // R2
   tx_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_gnt) |-> ($past(bus_idle) && $past(tx_req)));

   // R3
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_gnt && !rx_done) |=> rx_gnt);

   // R3
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_gnt && !tx_done) |=> tx_gnt);

   // R3
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_gnt && rx_done) || (tx_gnt && tx_done)) |=> bus_idle);

   // R4
   lone_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_idle && rx_req && !tx_req) |=> rx_gnt);

   // R4
   lone_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_idle && tx_req && !rx_req) |=> tx_gnt);

   // R5
   strict_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_idle && rx_req && tx_req && strict_mode) |=> rx_gnt);

   // R9
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_idle && !rx_req && !tx_req) |=> bus_idle);

endmodule

bind dma_pair_arbiter dma_pair_arbiter_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_req      (rx_req),
   .tx_req      (tx_req),
   .rx_done     (rx_done),
   .tx_done     (tx_done),
   .strict_mode (strict_mode),
   .rx_gnt      (rx_gnt),
   .tx_gnt      (tx_gnt)
);

// File: tb/tb_dma_pair_arbiter.sv
`timescale 1ns/1ps
module tb_dma_pair_arbiter;

   localparam int RW    = 2;
   localparam int BURST = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_req = 1'b0, tx_req = 1'b0;
   logic          rx_done = 1'b0, tx_done = 1'b0;
   logic          strict_mode = 1'b0;
   logic [RW-1:0] ratio_code = '0;
   logic          rx_gnt, tx_gnt;

   always #4 clk = ~clk;

   dma_pair_arbiter #(.RATIO_W(RW)) dut (
      .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .tx_req(tx_req),
      .rx_done(rx_done), .tx_done(tx_done), .ratio_code(ratio_code),
      .strict_mode(strict_mode), .rx_gnt(rx_gnt), .tx_gnt(tx_gnt));

   int    vectors = 0, misses = 0;
   string tag = "R1";
   bit    auto_done = 1'b1;
   bit    finished = 1'b0;

   // behavioural reference: 0 idle, 1 receive, 2 transmit
   int m_own = 0, m_cnt = 0, m_code = 0;
   int log_q[$];
   bit p_rx = 0, p_tx = 0;
   int rx_age = 0, tx_age = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_own = 0; m_cnt = 0; m_code = 0;
      end else begin
         int code_now, base, quota;
         code_now = int'(ratio_code);
         base  = (code_now != m_code) ? 0 : m_cnt;
         quota = code_now + 1;
         m_cnt = base;
         if (m_own == 0) begin
            if (rx_req && tx_req) begin
               if (strict_mode) m_own = 1;
               else if (base >= quota) begin m_own = 2; m_cnt = 0; end
               else begin m_own = 1; m_cnt = base + 1; end
            end else if (rx_req) m_own = 1;
            else if (tx_req) m_own = 2;
         end else if ((m_own == 1 && rx_done) || (m_own == 2 && tx_done)) begin
            m_own = 0;
         end
         m_code = code_now;
      end
   end

   always @(negedge clk) begin
      bit e_rx, e_tx;
      e_rx = (m_own == 1);
      e_tx = (m_own == 2);
      vectors++;
      if (rx_gnt !== e_rx || tx_gnt !== e_tx) begin
         misses++;
         $display("FAIL %s: grants rx,tx = %b,%b expected %b,%b at %0t",
                  tag, rx_gnt, tx_gnt, e_rx, e_tx, $time);
      end
      if (rx_gnt && !p_rx) log_q.push_back(1);
      if (tx_gnt && !p_tx) log_q.push_back(2);
      p_rx = rx_gnt;
      p_tx = tx_gnt;
      if (auto_done) begin
         rx_age  = rx_gnt ? rx_age + 1 : 0;
         tx_age  = tx_gnt ? tx_age + 1 : 0;
         rx_done = rx_gnt && (rx_age == BURST);
         tx_done = tx_gnt && (tx_age == BURST);
      end
   end

   task automatic chk(input string r, input bit ok, input string what,
                      input int act, input int exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s: %s actual %0d expected %0d", r, what, act, exp);
      end
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (!rx_gnt && !tx_gnt) break;
      end
   endtask

   task automatic wait_log(input int n);
      for (int i = 0; i < 400; i++) begin
         if (log_q.size() >= n) break;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: held in reset
      chk("R1", rx_gnt === 1'b0 && tx_gnt === 1'b0, "grants in reset",
          int'({rx_gnt, tx_gnt}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", rx_gnt === 1'b0 && tx_gnt === 1'b0, "grants after reset",
          int'({rx_gnt, tx_gnt}), 0);

      // R9: no requests, bus stays idle
      tag = "R9";
      repeat (5) @(negedge clk);
      chk("R9", !rx_gnt && !tx_gnt, "idle without requests",
          int'({rx_gnt, tx_gnt}), 0);

      // R4: lone requesters
      tag = "R4";
      ratio_code = 2'b01;
      rx_req = 1'b1;
      log_q.delete();
      repeat (16) @(negedge clk);
      rx_req = 1'b0;
      wait_idle();
      chk("R4", log_q.size() >= 3 && !(2 inside {log_q}), "lone rx grants",
          log_q.size(), 3);
      log_q.delete();
      tx_req = 1'b1;
      repeat (16) @(negedge clk);
      tx_req = 1'b0;
      wait_idle();
      chk("R4", log_q.size() >= 3 && !(1 inside {log_q}), "lone tx grants",
          log_q.size(), 3);

      // R7: an uncontended grant leaves the count alone (ratio 2:1)
      tag = "R7";
      log_q.delete();
      rx_req = 1'b1; tx_req = 1'b1;
      wait_log(1);
      tx_req = 1'b0;
      wait_log(2);
      tx_req = 1'b1;
      wait_log(4);
      chk("R7", log_q[2] == 1, "third grant owner", log_q[2], 1);
      chk("R7", log_q[3] == 2, "fourth grant owner", log_q[3], 2);
      rx_req = 1'b0; tx_req = 1'b0;
      wait_idle();

      // R5: strict receive priority
      tag = "R5";
      strict_mode = 1'b1;
      log_q.delete();
      rx_req = 1'b1; tx_req = 1'b1;
      repeat (40) @(negedge clk);
      rx_req = 1'b0; tx_req = 1'b0;
      wait_idle();
      chk("R5", !(2 inside {log_q}) && log_q.size() >= 5,
          "rx-only grants under strict mode", log_q.size(), 5);
      strict_mode = 1'b0;

      // R6: every ratio code under steady contention
      tag = "R6";
      foreach (log_q[i]) ; // no-op keeps queue usage simple
      for (int k = 0; k < 4; k++) begin
         int code;
         int plen;
         code = (k == 0) ? 3 : (k == 1) ? 0 : (k == 2) ? 2 : 1;
         plen = code + 2;
         log_q.delete();
         ratio_code = RW'(code);
         rx_req = 1'b1; tx_req = 1'b1;
         wait_log(2 * plen);
         for (int j = 0; j < 2 * plen; j++) begin
            int want;
            want = ((j % plen) == plen - 1) ? 2 : 1;
            chk("R6", log_q[j] == want, $sformatf("code %0d grant %0d", code, j),
                log_q[j], want);
         end
         rx_req = 1'b0; tx_req = 1'b0;
         wait_idle();
      end

      // R8: a code change mid-run clears the count
      tag = "R8";
      ratio_code = 2'b11;
      log_q.delete();
      rx_req = 1'b1; tx_req = 1'b1;
      wait_log(2);
      ratio_code = 2'b00;
      wait_log(4);
      chk("R8", log_q[2] == 1, "first grant after code change", log_q[2], 1);
      chk("R8", log_q[3] == 2, "second grant after code change", log_q[3], 2);
      rx_req = 1'b0; tx_req = 1'b0;
      wait_idle();

      // R3: hold until own burst end, foreign burst end ignored
      tag = "R3";
      auto_done = 1'b0;
      rx_done = 1'b0; tx_done = 1'b0;
      rx_req = 1'b1;
      for (int i = 0; i < 10 && !rx_gnt; i++) @(negedge clk);
      rx_req = 1'b0;
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      repeat (2) @(negedge clk);
      chk("R3", rx_gnt === 1'b1, "rx grant after foreign burst end", int'(rx_gnt), 1);
      rx_done = 1'b1;
      @(negedge clk);
      rx_done = 1'b0;
      chk("R3", rx_gnt === 1'b0, "rx grant after own burst end", int'(rx_gnt), 0);
      auto_done = 1'b1;
      wait_idle();

      // R2: idle gap between bursts, never both grants
      tag = "R2";
      begin
         int both_cnt, gap_cnt;
         bit was_busy;
         both_cnt = 0; gap_cnt = 0; was_busy = 0;
         rx_req = 1'b1; tx_req = 1'b1;
         for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (rx_gnt && tx_gnt) both_cnt++;
            if (was_busy && !rx_gnt && !tx_gnt) gap_cnt++;
            was_busy = rx_gnt || tx_gnt;
         end
         chk("R2", both_cnt == 0, "cycles with both grants", both_cnt, 0);
         chk("R2", gap_cnt >= 10, "idle cycles between bursts", gap_cnt, 10);
         rx_req = 1'b0; tx_req = 1'b0;
      end
      wait_idle();

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         misses++;
         $display("FAIL watchdog: run incomplete actual 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

endmodule